// File: doc/BRIEF.md
# Third-Order Fractional Divide-Value Sequencer

This block feeds the feedback counter of a fractional-N synthesizer loop. For every feedback-divider period the surrounding logic pulses an update strobe, and the block answers on the next system clock with one integer divide value. The long-run mean of these values lands on a 12-bit integer setting plus a 25-bit fractional numerator taken over a fixed modulus of 2^25. The rounding error of each step is pushed to high offset frequencies by a cascade of three first-order accumulators whose overflow bits are combined into a third-order correction term.

The first accumulator always adds one extra bit set to 1 below the least significant fractional bit. This places a permanent offset of half a fractional step on the mean, which is part of the intended transfer and is not trimmed out. The integer and fractional settings are taken only on the strobe, so software or a ramp engine may change them at any time without ever producing a divide value built from a mix of old and new settings.

Top module: `frac_div_seq`

## Requirements
- R1: When `step_i` is high at a rising clock edge, `div_o` and `div_vld_o` take their new values at that edge; `div_vld_o` is high for exactly the clock cycle that follows each strobe cycle and low otherwise.
- R2: Between strobes `div_o` holds its last value.
- R3: `int_i` and `frac_i` are sampled only on strobe edges; changing them while `step_i` is low has no effect on `div_o` or on later outputs.
- R4: Every divide value lies in the range `int_i - 3` to `int_i + 4` of the setting sampled on its strobe; `div_o` is 13 bits wide, so an integer setting of 4095 plus a correction of +4 does not wrap.
- R5: Starting from reset, the sum of the first N divide values equals N*INT + floor(N*(2*FRAC+1)/2^26) plus an end term between -1 and +2, so the mean tends to INT + FRAC/2^25 + 1/2^26 (the half-step offset).
- R6: The first divide value after reset equals the integer setting; with FRAC = 0 the first 700 divide values all equal the integer setting.
- R7: Synchronous reset (`rst_i` high at a clock edge) clears all accumulators, carry delays, `div_o` (to 0) and `div_vld_o`; the same input sequence after any reset yields the same divide sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One-cycle strobe per feedback-divider period |
| int_i | input | 12 | Integer part of the division ratio, legal 23 to 4095 |
| frac_i | input | 25 | Fractional numerator over 2^25 |
| div_o | output | 13 | Instantaneous divide value |
| div_vld_o | output | 1 | High for the cycle in which a new divide value is presented |

## Verification
The main function is driven with a zero fraction, a fraction of one, the all-ones fraction, an exact half, and several irregular numerators, at integer settings from the minimum 23 up to 4095. The zero fraction separates the half-step offset and the higher-order stages from the first stage, since only the third accumulator can overflow early; the all-ones fraction forces a first-stage carry on nearly every step and exposes output wrap at the top integer. Irregular numerators over long runs show whether the carry combination telescopes to the exact floor value of the mean, which any wrong sign or missing delay in the correction breaks.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned STAGES = 3;
  localparam int unsigned CORR_W = 4;
  typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/frac_acc_stage.sv
module frac_acc_stage #(
  parameter int unsigned W = 26
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   total;

  always_comb begin
    total   = {1'b0, acc_q} + {1'b0, add_i};
    sum_o   = total[W-1:0];
    carry_o = total[W];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end

  // R5: an overflow leaves a wrapped sum smaller than the addend
  p_carry_wrap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && carry_o) |-> (sum_o < add_i));
endmodule

// File: rtl/frac_noise_shaper.sv
module frac_noise_shaper
  import frac_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [STAGES-1:0] carry_i,
  output corr_t             corr_o
);
  logic c2_d1;
  logic c3_d1;
  logic c3_d2;

  always_comb begin
    corr_o = corr_t'(carry_i[0])
           + corr_t'(carry_i[1]) - corr_t'(c2_d1)
           + corr_t'(carry_i[2]) - corr_t'(2 * c3_d1) + corr_t'(c3_d2);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (en_i) begin
      c2_d1 <= carry_i[1];
      c3_d1 <= carry_i[2];
      c3_d2 <= c3_d1;
    end
  end
endmodule

// File: rtl/frac_div_seq.sv
module frac_div_seq
  import frac_div_pkg::*;
#(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W:0]    div_o,
  output logic              div_vld_o
);
  localparam int unsigned ACC_W = FRAC_W + 1;
  localparam int unsigned OUT_W = INT_W + 1;

  logic [ACC_W-1:0]  stage_add [STAGES];
  logic [ACC_W-1:0]  stage_sum [STAGES];
  logic [STAGES-1:0] carries;
  corr_t             corr;
  logic [OUT_W-1:0]  div_next;

  // half-step offset: constant 1 below the fractional LSB
  assign stage_add[0] = {frac_i, 1'b1};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s > 0) begin : g_link
      assign stage_add[s] = stage_sum[s-1];
    end
    frac_acc_stage #(.W(ACC_W)) acc_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (step_i),
      .add_i   (stage_add[s]),
      .sum_o   (stage_sum[s]),
      .carry_o (carries[s])
    );
  end

  frac_noise_shaper shp_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (step_i),
    .carry_i (carries),
    .corr_o  (corr)
  );

  assign div_next = {1'b0, int_i} + {{(OUT_W-CORR_W){corr[CORR_W-1]}}, corr};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_o     <= '0;
      div_vld_o <= 1'b0;
    end else begin
      div_vld_o <= step_i;
      if (step_i) div_o <= div_next;
    end
  end

  logic fresh_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)       fresh_q <= 1'b1;
    else if (step_i) fresh_q <= 1'b0;
  end

  p_corr_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i |-> (corr >= -3 && corr <= 4));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(div_o));

  p_first_out_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (fresh_q && step_i) |=> (div_o == {1'b0, $past(int_i)}));

  p_half_lsb_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i |=> (stage_sum[0][0] != $past(stage_sum[0][0])));
endmodule

// File: tb/frac_div_seq_tb_top.sv
`timescale 1ns/1ps
module frac_div_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [11:0] int_v = 12'd23;
  logic [24:0] frac_v = '0;
  logic [12:0] div;
  logic        vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_div_seq dut_i (
    .clk_i(clk), .rst_i(rst), .step_i(step),
    .int_i(int_v), .frac_i(frac_v),
    .div_o(div), .div_vld_o(vld)
  );

  // int[53:42], frac[41:17], count[16:0]
  localparam logic [53:0] VECS [7] = '{
    {12'd23,   25'd0,        17'd4096},
    {12'd100,  25'd1,        17'd4096},
    {12'd181,  25'd13631488, 17'd65536},
    {12'd4095, 25'd33554431, 17'd4096},
    {12'd1000, 25'd16777216, 17'd4096},
    {12'd2047, 25'd5592405,  17'd4096},
    {12'd500,  25'd12345678, 17'd8192}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [12:0] rec [64];
    logic [12:0] held;
    int bad;

    do_reset();
    chk(div == 13'd0, "R7 reset div", div, 0);
    chk(vld == 1'b0, "R7 reset valid", vld, 0);

    // table walk: range (R4) and exact running sum (R5)
    for (int v = 0; v < 7; v++) begin
      longint n, iv, fv, sum, base, diff;
      iv = VECS[v][53:42]; fv = VECS[v][41:17]; n = VECS[v][16:0];
      do_reset();
      int_v = VECS[v][53:42]; frac_v = VECS[v][41:17];
      sum = 0; bad = 0;
      step = 1'b1;
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        if (i == n - 1) step = 1'b0;
        sum += div;
        if (!vld || longint'(div) < iv - 3 || longint'(div) > iv + 4) bad++;
      end
      chk(bad == 0, "R4 range/valid", bad, 0);
      base = n * iv + ((n * (2 * fv + 1)) >> 26);
      diff = sum - base;
      chk(diff >= -1 && diff <= 2, "R5 mean", sum, base);
    end

    // R6: zero fraction, first 700 values exactly INT
    do_reset();
    int_v = 12'd300; frac_v = '0; bad = 0;
    step = 1'b1;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (i == 0) chk(div == 13'd300, "R6 first output", div, 300);
      if (i == 699) step = 1'b0;
      if (div != 13'd300) bad++;
    end
    chk(bad == 0, "R6 zero-frac run", bad, 0);

    // R1: single strobe -> valid for one cycle
    do_reset();
    int_v = 12'd777; frac_v = 25'd9999;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk(vld == 1'b1, "R1 valid after strobe", vld, 1);
    chk(div == 13'd777, "R1 value after strobe", div, 777);
    @(negedge clk);
    chk(vld == 1'b0, "R1 valid drops", vld, 0);

    // R2/R3: input changes without strobe are ignored
    held = div;
    int_v = 12'd900; frac_v = 25'd33554431;
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (div != held || vld) bad++;
    end
    chk(bad == 0, "R2 hold without strobe", div, held);
    chk(div == held, "R3 inputs ignored off strobe", div, held);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk(div >= 13'd897 && div <= 13'd904, "R3 new setting on strobe", div, 900);

    // R7: same sequence after reset repeats exactly
    do_reset();
    int_v = 12'd1234; frac_v = 25'd7654321;
    step = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rec[i] = div;
    end
    step = 1'b0;
    do_reset();
    bad = 0;
    step = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (div != rec[i]) bad++;
    end
    step = 1'b0;
    chk(bad == 0, "R7 replay after reset", bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule